// File: doc/BRIEF.md
# AHB Master Burst Splitter

The block turns a request for a run of consecutive 32-bit words into bus transfers on an AHB-Lite style master port. It only ever issues three packet shapes: a single word, a four-beat incrementing burst or an eight-beat incrementing burst. Any other word count is cut into a greedy sequence of those shapes, largest first. Transfers are pipelined, so the address phase of one beat overlaps the data phase of the one before it.

Two events can break a burst partway through. One is a two-cycle SPLIT or RETRY answer from the slave. The other is the loss of the bus grant while a burst is running. In both cases the beats of that burst that have not completed are finished as individual single transfers, and greedy packing resumes for any words after them. A RETRY or SPLIT sends the failed beat back out first, at the same address. The core side sees a ready flag that accepts a new request while the block is idle. It also sees one beat pulse per completed word and a one-cycle done pulse after the final word.

Top module: `ahb_burst_split`

## Requirements
- R1: Every non-IDLE transfer has hsize = 3'b010 (word). hburst is one of SINGLE 3'b000, INCR4 3'b011 or INCR8 3'b101. hwrite equals the write flag of the request.
- R2: With no interruption, a request of N words is issued as packets chosen greedily: INCR8 while at least 8 words remain, then INCR4 while at least 4 remain, then SINGLE. For example, 12 words go out as one INCR8 followed by one INCR4.
- R3: The first beat of each packet has htrans NONSEQ (2'b10) and later beats have SEQ (2'b11). Each accepted beat's haddr is 4 above the previous accepted beat's address within the request.
- R4: When a data phase gets SPLIT (hresp 2'b11) or RETRY (2'b10) with hready low, htrans is IDLE (2'b00) in the next cycle. The failed beat is then reissued as a NONSEQ SINGLE at its own address once hgrant is high. The rest of that burst follows as NONSEQ SINGLE transfers.
- R5: If hgrant is low while a SEQ beat is driven with hready high, that beat is not taken and htrans is IDLE in the next cycle. The remaining beats of the burst are later issued as NONSEQ SINGLE transfers.
- R6: While hready is low and hresp is not SPLIT or RETRY, a driven transfer keeps haddr, htrans and hburst unchanged into the next cycle.
- R7: beat_ok is high for one cycle for each word whose data phase completes (hready high, hresp OKAY 2'b00 or ERROR 2'b01). done is high for exactly one cycle, in the cycle after the final word's data phase completes.
- R8: A request is taken only in a cycle where req_ready and req_valid are both high and req_words is non-zero. req_ready is low while a request is in progress, and a req_valid pulse in that time changes nothing on the bus.
- R9: After reset htrans is IDLE, req_ready is high, and beat_ok and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a transfer run |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | AW | Word-aligned start address |
| req_words | input | CW | Number of words in the run |
| req_write | input | 1 | 1 for write, 0 for read |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Transfer size, always word |
| haddr | output | AW | Transfer address |
| hwrite | output | 1 | Transfer direction |
| hready | input | 1 | Slave ready / transfer done |
| hresp | input | 2 | Slave response |
| hgrant | input | 1 | Bus granted to this master |
| beat_ok | output | 1 | One word's data phase completed |
| done | output | 1 | Whole run completed (one-cycle pulse) |

## Verification
A wrong internal state shows up first in the address sequence. A wrong word or packet count gives the wrong mix of NONSEQ packet starts, or an extra or missing beat, within a few cycles. It also shifts the cycle of done against the last beat_ok. A failed rollback after RETRY or SPLIT shows as a reissued address other than the failed beat's, or as a SEQ beat after the interruption, in the third cycle after the error begins. A held output that moves during a wait state is seen in the very next cycle.

// File: rtl/ahb_split_pkg.sv
package ahb_split_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] BU_SINGLE = 3'b000;
    localparam logic [2:0] BU_INCR4  = 3'b011;
    localparam logic [2:0] BU_INCR8  = 3'b101;
    localparam logic [2:0] SZ_WORD   = 3'b010;

endpackage

// File: rtl/ahb_split_pick.sv
module ahb_split_pick
    import ahb_split_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [CW-1:0] words_left,
    output logic [3:0]    pkt_len,
    output logic [2:0]    pkt_burst
);
    localparam logic [CW-1:0] EIGHT = CW'(8);
    localparam logic [CW-1:0] FOUR  = CW'(4);

    // greedy choice: largest packet that still fits
    always_comb begin
        if (words_left >= EIGHT) begin
            pkt_len   = 4'd8;
            pkt_burst = BU_INCR8;
        end else if (words_left >= FOUR) begin
            pkt_len   = 4'd4;
            pkt_burst = BU_INCR4;
        end else begin
            pkt_len   = 4'd1;
            pkt_burst = BU_SINGLE;
        end
    end
endmodule

// File: rtl/ahb_split_resp.sv
module ahb_split_resp (
    input  logic       dp_live,
    input  logic       hready,
    input  logic [1:0] hresp,
    output logic       beat_good,
    output logic       beat_fail
);
    // hresp[1] set means RETRY or SPLIT; first cycle has hready low
    always_comb begin
        beat_good = dp_live && hready && !hresp[1];
        beat_fail = dp_live && !hready && hresp[1];
    end
endmodule

// File: rtl/ahb_burst_split.sv
module ahb_burst_split
    import ahb_split_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_words,
    input  logic          req_write,
    output logic [1:0]    htrans,
    output logic [2:0]    hburst,
    output logic [2:0]    hsize,
    output logic [AW-1:0] haddr,
    output logic          hwrite,
    input  logic          hready,
    input  logic [1:0]    hresp,
    input  logic          hgrant,
    output logic          beat_ok,
    output logic          done
);
    localparam logic [AW-1:0] STEP  = AW'(4);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        logic          act;
        logic          seq;
        logic [2:0]    burst;
        logic [AW-1:0] addr;
        logic          wr;
        logic [CW-1:0] todo;
        logic [3:0]    pkt;
        logic [CW-1:0] fb;
        logic          dp;
        logic [AW-1:0] dp_addr;
        logic          done;
    } state_t;

    state_t s_d, s_q;

    logic          dp_live;
    logic          beat_good, beat_fail, acc;
    logic [3:0]    new_len, pkt_a;
    logic [2:0]    new_burst;
    logic [CW-1:0] todo_a, fb_a;
    logic [AW-1:0] addr_a;

    assign dp_live = s_q.dp;

    ahb_split_resp u_resp (
        .dp_live   (dp_live),
        .hready    (hready),
        .hresp     (hresp),
        .beat_good (beat_good),
        .beat_fail (beat_fail)
    );

    ahb_split_pick #(.CW(CW)) u_pick (
        .words_left (todo_a),
        .pkt_len    (new_len),
        .pkt_burst  (new_burst)
    );

    always_comb begin
        acc    = s_q.act && hready && hgrant;
        todo_a = s_q.todo - (acc ? ONE_C : '0);
        pkt_a  = s_q.pkt - {3'b000, acc};
        fb_a   = (acc && s_q.fb != '0) ? s_q.fb - ONE_C : s_q.fb;
        addr_a = acc ? s_q.addr + STEP : s_q.addr;
        // grant taken away in the middle of a burst: rest goes as singles
        if (s_q.act && !hgrant && s_q.seq) begin
            fb_a  = CW'(s_q.pkt);
            pkt_a = 4'd0;
        end

        s_d      = s_q;
        s_d.done = 1'b0;

        if (beat_fail) begin
            // roll back to the failed beat; driven beat was not taken
            s_d.act  = 1'b0;
            s_d.seq  = 1'b0;
            s_d.dp   = 1'b0;
            s_d.addr = s_q.dp_addr;
            s_d.todo = s_q.todo + ONE_C;
            s_d.fb   = (s_q.act && s_q.seq) ? CW'(s_q.pkt) + ONE_C : s_q.fb + ONE_C;
            s_d.pkt  = 4'd0;
        end else if (hready) begin
            s_d.done = beat_good && (s_q.todo == '0);
            s_d.dp   = acc;
            if (acc) begin
                s_d.dp_addr = s_q.addr;
            end
            s_d.todo = todo_a;
            s_d.fb   = fb_a;
            s_d.addr = addr_a;
            s_d.pkt  = pkt_a;
            s_d.seq  = 1'b0;
            s_d.act  = 1'b0;
            if (hgrant && todo_a != '0) begin
                s_d.act = 1'b1;
                if (fb_a != '0) begin
                    s_d.burst = BU_SINGLE;
                    s_d.pkt   = 4'd1;
                end else if (pkt_a != 4'd0) begin
                    s_d.seq = acc;
                end else begin
                    s_d.burst = new_burst;
                    s_d.pkt   = new_len;
                end
            end
        end

        if (req_ready && req_valid && req_words != '0) begin
            s_d.todo = req_words;
            s_d.addr = req_addr;
            s_d.wr   = req_write;
            s_d.pkt  = 4'd0;
            s_d.fb   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = !s_q.act && !s_q.dp && (s_q.todo == '0);
    assign htrans    = !s_q.act ? TR_IDLE : (s_q.seq ? TR_SEQ : TR_NONSEQ);
    assign hburst    = s_q.burst;
    assign hsize     = SZ_WORD;
    assign haddr     = s_q.addr;
    assign hwrite    = s_q.wr;
    assign beat_ok   = beat_good;
    assign done      = s_q.done;
endmodule

// File: rtl/ahb_split_chk.sv
module ahb_split_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    htrans,
    input logic [2:0]    hburst,
    input logic [2:0]    hsize,
    input logic [AW-1:0] haddr,
    input logic          hready,
    input logic [1:0]    hresp,
    input logic          hgrant,
    input logic          done,
    input logic          dp_live
);
    AST_WORD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> (hsize == 3'b010)); // R1
    AST_LEGAL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> (hburst == 3'b000 || hburst == 3'b011 || hburst == 3'b101)); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && hgrant && htrans != 2'b00) |=> (htrans != 2'b11 || haddr == $past(haddr) + AW'(4))); // R3
    AST_SEQ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> (hburst != 3'b000)); // R3
    AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_live && !hready && hresp[1]) |=> (htrans == 2'b00)); // R4
    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11 && hready && !hgrant) |=> (htrans == 2'b00)); // R5
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00 && !hready && !hresp[1]) |=> ($stable(haddr) && $stable(htrans) && $stable(hburst))); // R6
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

bind ahb_burst_split ahb_split_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .htrans  (htrans),
    .hburst  (hburst),
    .hsize   (hsize),
    .haddr   (haddr),
    .hready  (hready),
    .hresp   (hresp),
    .hgrant  (hgrant),
    .done    (done),
    .dp_live (dp_live)
);

// File: tb/test_ahb_burst_split.sv
module test_ahb_burst_split;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  words;
        logic        wr;
        logic [3:0]  n8;
        logic [3:0]  n4;
        logic [3:0]  n1;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{32'h1000, 8'd1,  1'b0, 4'd0, 4'd0, 4'd1},
        '{32'h2000, 8'd4,  1'b1, 4'd0, 4'd1, 4'd0},
        '{32'h3000, 8'd8,  1'b0, 4'd1, 4'd0, 4'd0},
        '{32'h4000, 8'd12, 1'b1, 4'd1, 4'd1, 4'd0},
        '{32'h5000, 8'd3,  1'b0, 4'd0, 4'd0, 4'd3},
        '{32'h6000, 8'd13, 1'b1, 4'd1, 4'd1, 4'd1},
        '{32'h7000, 8'd21, 1'b0, 4'd2, 4'd1, 4'd1},
        '{32'h8000, 8'd7,  1'b1, 4'd0, 4'd1, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_words = '0;
    logic        req_write = 1'b0;
    logic [1:0]  htrans;
    logic [2:0]  hburst, hsize;
    logic [31:0] haddr;
    logic        hwrite;
    logic        hready = 1'b1;
    logic [1:0]  hresp = 2'b00;
    logic        hgrant = 1'b1;
    logic        beat_ok, done;

    ahb_burst_split i_ahb_burst_split (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_words(req_words), .req_write(req_write),
        .htrans(htrans), .hburst(hburst), .hsize(hsize), .haddr(haddr), .hwrite(hwrite),
        .hready(hready), .hresp(hresp), .hgrant(hgrant), .beat_ok(beat_ok), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0;
    int cyc = 0, log_n = 0, n8 = 0, n4 = 0, n1 = 0, seq_n = 0;
    int ok_n = 0, done_n = 0, last_ok = 0, done_cyc = 0, addr_err = 0, ctl_err = 0;
    logic [31:0] exp_addr = '0;
    logic        exp_wr = 1'b0;
    logic [31:0] log_addr [0:63];
    logic [1:0]  log_tr   [0:63];
    logic [2:0]  log_bu   [0:63];

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && hready && hgrant && htrans != 2'b00) begin
            if (log_n < 64) begin
                log_addr[log_n] = haddr;
                log_tr[log_n]   = htrans;
                log_bu[log_n]   = hburst;
            end
            if (htrans == 2'b10) begin
                if (hburst == 3'b101) n8 = n8 + 1;
                else if (hburst == 3'b011) n4 = n4 + 1;
                else n1 = n1 + 1;
            end else begin
                seq_n = seq_n + 1;
            end
            if (haddr != exp_addr) addr_err = addr_err + 1;
            exp_addr = exp_addr + 32'd4;
            if (hsize != 3'b010 || hwrite != exp_wr) ctl_err = ctl_err + 1;
            log_n = log_n + 1;
        end
        if (rst_n && beat_ok) begin
            ok_n = ok_n + 1;
            last_ok = cyc;
        end
        if (rst_n && done) begin
            done_n = done_n + 1;
            done_cyc = cyc;
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        tests = tests + 1;
        if (!cond) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        log_n = 0; n8 = 0; n4 = 0; n1 = 0; seq_n = 0;
        ok_n = 0; done_n = 0; addr_err = 0; ctl_err = 0;
    endtask

    task automatic issue(input logic [31:0] a, input logic [7:0] w, input logic wr);
        @(posedge clk); #1;
        clear_counts();
        exp_addr = a; exp_wr = wr;
        req_addr = a; req_words = w; req_write = wr; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && done_n == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_acc(input int k);
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            if (log_n >= k) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(htrans == 2'b00, "R9", "htrans after reset", htrans, 0);
        chk(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);
        chk(done == 1'b0 && beat_ok == 1'b0, "R9", "done/beat_ok after reset", {done, beat_ok}, 0);

        // table walk, ideal slave
        foreach (VEC[v]) begin
            issue(VEC[v].addr, VEC[v].words, VEC[v].wr);
            wait_done();
            chk(n8 == int'(VEC[v].n8), "R2", "INCR8 count", n8, VEC[v].n8);
            chk(n4 == int'(VEC[v].n4), "R2", "INCR4 count", n4, VEC[v].n4);
            chk(n1 == int'(VEC[v].n1), "R2", "SINGLE count", n1, VEC[v].n1);
            chk(seq_n == 7*int'(VEC[v].n8) + 3*int'(VEC[v].n4), "R3", "SEQ beats", seq_n,
                7*int'(VEC[v].n8) + 3*int'(VEC[v].n4));
            chk(addr_err == 0, "R3", "address step errors", addr_err, 0);
            chk(ctl_err == 0, "R1", "size/direction errors", ctl_err, 0);
            chk(ok_n == int'(VEC[v].words), "R7", "beat_ok pulses", ok_n, VEC[v].words);
            chk(done_n == 1, "R7", "done pulses", done_n, 1);
            chk(done_cyc == last_ok + 1, "R7", "done cycle", done_cyc, last_ok + 1);
        end

        // RETRY on the third beat of an 8-beat burst
        issue(32'h100, 8'd8, 1'b0);
        wait_acc(3);
        hready = 1'b0; hresp = 2'b10;
        @(posedge clk); #1;
        hready = 1'b1;
        @(negedge clk);
        chk(htrans == 2'b00, "R4", "htrans in second response cycle", htrans, 0);
        @(posedge clk); #1;
        hresp = 2'b00;
        wait_done();
        chk(log_n == 9, "R4", "transfers with retry", log_n, 9);
        bad = 0;
        for (int i = 3; i < 9; i++)
            if (log_addr[i] != 32'h108 + 32'(4*(i-3)) || log_tr[i] != 2'b10 || log_bu[i] != 3'b000)
                bad = bad + 1;
        chk(bad == 0, "R4", "reissue as singles from failed address", bad, 0);
        chk(log_addr[3] == 32'h108, "R4", "first reissued address", log_addr[3], 32'h108);
        chk(ok_n == 8 && done_n == 1, "R7", "beats after retry", ok_n, 8);

        // SPLIT on the first beat of a 4-beat burst, grant withdrawn
        issue(32'h300, 8'd4, 1'b1);
        wait_acc(1);
        hready = 1'b0; hresp = 2'b11;
        @(posedge clk); #1;
        hready = 1'b1; hgrant = 1'b0;
        @(posedge clk); #1;
        hresp = 2'b00;
        @(posedge clk); #1;
        hgrant = 1'b1;
        wait_done();
        chk(log_n == 5, "R4", "transfers with split", log_n, 5);
        bad = 0;
        for (int i = 1; i < 5; i++)
            if (log_addr[i] != 32'h300 + 32'(4*(i-1)) || log_tr[i] != 2'b10 || log_bu[i] != 3'b000)
                bad = bad + 1;
        chk(bad == 0, "R4", "split remainder as singles", bad, 0);

        // grant lost mid-burst
        issue(32'h200, 8'd4, 1'b0);
        wait_acc(2);
        hgrant = 1'b0;
        @(negedge clk);
        chk(htrans == 2'b11, "R5", "SEQ driven when grant drops", htrans, 3);
        @(posedge clk); #1;
        @(negedge clk);
        chk(htrans == 2'b00, "R5", "idle after grant loss", htrans, 0);
        @(posedge clk); #1;
        hgrant = 1'b1;
        wait_done();
        chk(log_n == 4 && log_addr[2] == 32'h208 && log_bu[2] == 3'b000 && log_tr[3] == 2'b10
            && log_addr[3] == 32'h20C && log_bu[3] == 3'b000, "R5", "singles after grant loss", log_n, 4);
        chk(ok_n == 4 && done_n == 1, "R7", "beats after grant loss", ok_n, 4);

        // wait states hold the driven beat
        issue(32'h400, 8'd4, 1'b1);
        wait_acc(1);
        hready = 1'b0;
        @(negedge clk);
        chk(htrans == 2'b11 && haddr == 32'h404, "R6", "held in first wait", haddr, 32'h404);
        @(posedge clk); #1;
        @(negedge clk);
        chk(htrans == 2'b11 && haddr == 32'h404 && hburst == 3'b011, "R6", "held in second wait",
            haddr, 32'h404);
        @(posedge clk); #1;
        hready = 1'b1;
        wait_done();
        chk(ok_n == 4 && addr_err == 0, "R6", "run completes after waits", ok_n, 4);

        // a request during a run is ignored
        issue(32'h500, 8'd8, 1'b0);
        @(posedge clk); #1;
        req_addr = 32'h9000; req_words = 8'd1; req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R8", "req_ready while busy", req_ready, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_done();
        repeat (6) @(negedge clk);
        chk(log_n == 8 && ok_n == 8 && addr_err == 0, "R8", "transfers with ignored request", log_n, 8);
        chk(req_ready == 1'b1 && htrans == 2'b00, "R8", "idle after run", req_ready, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule